// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the microprogram counter of a microcoded control unit and chooses the control-store address of the next microinstruction on every clock. The address comes from the next-address field of the current microinstruction. A two-bit condition mode says how that field is used. It can be taken as it stands, as a plain jump. It can have its lowest bit replaced by one internal ALU flag, for a two-way branch. It can have its lowest four bits replaced by one nibble of the instruction register, for a sixteen-way opcode dispatch.

The control store sits outside the block. It presents the fields of the microinstruction currently addressed by `mpc_o`. The sequencer combines those fields with the flags and opcode present in the same cycle, and it registers the result at the next rising edge. A halt input holds the counter at its current value. A synchronous active-low reset returns it to address zero.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `mpc_o` becomes 0 after that edge, so execution restarts at microaddress 0.
- R2: With `cond_mode` = 2'b00 and no halt, `mpc_o` takes the value of `next_addr` after the edge, with no bit changed.
- R3: With `cond_mode` = 2'b01 and no halt, `mpc_o[8:1]` takes `next_addr[8:1]`, and `mpc_o[0]` takes the selected flag in place of `next_addr[0]`.
- R4: `alu_flags` is packed as {N,Z,V,C}, with N on bit 3 and C on bit 0. `test_sel` picks one of them: 2'b00 selects N, 2'b01 selects Z, 2'b10 selects V and 2'b11 selects C.
- R5: With `cond_mode` = 2'b10 and no halt, `mpc_o` becomes {`next_addr[8:4]`, `ir[7:4]`}.
- R6: With `cond_mode` = 2'b11 and no halt, `mpc_o` becomes {`next_addr[8:4]`, `ir[3:0]`}.
- R7: While `halt` is high and reset is not asserted, `mpc_o` keeps its value across clock edges, whatever the other inputs do.
- R8: Reset takes priority over halt. With both asserted, `mpc_o` still becomes 0.
- R9: The next address is formed only from the input values present at the clock edge. Input changes between edges do not alter `mpc_o` until the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Holds the microprogram counter when high |
| next_addr | input | 9 | Next-address field of the current microinstruction |
| cond_mode | input | 2 | Selects jump, flag branch, upper-nibble dispatch or lower-nibble dispatch |
| test_sel | input | 2 | Selects the flag used by a two-way branch |
| alu_flags | input | 4 | Internal ALU flags, packed as {N,Z,V,C} |
| ir | input | 8 | Instruction register holding the opcode |
| mpc_o | output | 9 | Registered microprogram counter |

## Verification
Jumps are driven with all-zero, all-one and alternating next-address patterns, so that a stuck or swapped address bit shows up.

Flag branches drive each test selection twice: once with only the chosen flag set, and once with only that flag clear. This separates a wrong flag index from a wrong bit position. The next-address field is given an odd lowest bit, so a branch that keeps the field's bit instead of the flag is caught.

Opcode dispatches use instruction values whose two nibbles differ, which shows whether the correct half was taken. The halt and sampling scenarios change every input between edges, which exposes any path that bypasses the register.

// File: rtl/useq_pkg.sv
// Package: shared types of the next-address sequencer.
// Assumes the condition mode is a 2-bit field of the microinstruction.
package useq_pkg;
    typedef enum logic [1:0] {
        SEQ_JUMP = 2'b00,   // field used unchanged
        SEQ_FLAG = 2'b01,   // bit 0 replaced by selected flag
        SEQ_OPHI = 2'b10,   // low nibble replaced by opcode upper nibble
        SEQ_OPLO = 2'b11    // low nibble replaced by opcode lower nibble
    } seq_mode_e;
endpackage

// File: rtl/useq_flag_sel.sv
// Module: picks one ALU flag for a two-way branch.
// Assumes flags are packed with the first-selectable flag (N) in the MSB,
// so select code k reads flag bit FLAG_N-1-k.
module useq_flag_sel #(
    parameter int FLAG_N = 4,
    localparam int SEL_W = $clog2(FLAG_N)
) (
    input  logic [FLAG_N-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              flag_o
);
    logic [FLAG_N-1:0] rev;

    // Reverse the packing so the select code indexes directly.
    for (genvar i = 0; i < FLAG_N; i++) begin : g_rev
        assign rev[i] = flags[FLAG_N-1-i];
    end

    // Select the tested flag.
    assign flag_o = rev[sel];
endmodule

// File: rtl/useq_addr_merge.sv
// Module: forms the next microaddress by substituting low-order bits.
// Assumes ADDR_W > NIB_W and an instruction register of two nibbles.
module useq_addr_merge
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int IR_W   = 8,
    localparam int NIB_W = IR_W / 2,
    localparam int KEEP_W = ADDR_W - NIB_W
) (
    input  logic [ADDR_W-1:0] field,
    input  seq_mode_e         mode,
    input  logic              flag,
    input  logic [IR_W-1:0]   ir,
    output logic [ADDR_W-1:0] nxt
);
    logic [NIB_W-1:0] nib_hi;
    logic [NIB_W-1:0] nib_lo;

    assign nib_hi = ir[IR_W-1 -: NIB_W];
    assign nib_lo = ir[NIB_W-1:0];

    // Choose which low-order bits of the field are replaced.
    always_comb begin
        unique case (mode)
            SEQ_JUMP: nxt = field;
            SEQ_FLAG: nxt = {field[ADDR_W-1:1], flag};
            SEQ_OPHI: nxt = {field[ADDR_W-1 -: KEEP_W], nib_hi};
            SEQ_OPLO: nxt = {field[ADDR_W-1 -: KEEP_W], nib_lo};
            default:  nxt = field;
        endcase
    end
endmodule

// File: rtl/useq_mpc_reg.sv
// Module: the microprogram counter register.
// Assumes synchronous active-low reset with priority over halt.
module useq_mpc_reg #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] mpc
);
    // Load the next address unless held or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mpc <= '0;
        else if (!halt)
            mpc <= nxt;
    end
endmodule

// File: rtl/useq_next_addr.sv
// Module: top of the next-address sequencer. It ties flag selection,
// address merge and the counter register together.
// Assumes all inputs are stable around the rising edge and come from
// the microinstruction addressed by mpc_o in the same cycle.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int IR_W   = 8,
    parameter int FLAG_N = 4,
    localparam int SEL_W = $clog2(FLAG_N),
    localparam int NIB_W = IR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [1:0]        cond_mode,
    input  logic [SEL_W-1:0]  test_sel,
    input  logic [FLAG_N-1:0] alu_flags,
    input  logic [IR_W-1:0]   ir,
    output logic [ADDR_W-1:0] mpc_o
);
    logic              flag_w;
    logic [ADDR_W-1:0] nxt_w;

    useq_flag_sel #(.FLAG_N(FLAG_N)) u_flag (
        .flags (alu_flags),
        .sel   (test_sel),
        .flag_o(flag_w)
    );

    useq_addr_merge #(.ADDR_W(ADDR_W), .IR_W(IR_W)) u_merge (
        .field(next_addr),
        .mode (seq_mode_e'(cond_mode)),
        .flag (flag_w),
        .ir   (ir),
        .nxt  (nxt_w)
    );

    useq_mpc_reg #(.ADDR_W(ADDR_W)) u_mpc (
        .clk  (clk),
        .rst_n(rst_n),
        .halt (halt),
        .nxt  (nxt_w),
        .mpc  (mpc_o)
    );

    // R1: first cycle out of reset starts at address 0
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mpc_o == '0);

    // R2: jump loads the field unchanged
    a_r2_jump_field: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == 2'b00 && !halt) |=> mpc_o == $past(next_addr));

    // R3: flag branch keeps the upper field bits
    a_r3_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == 2'b01 && !halt) |=> mpc_o[ADDR_W-1:1] == $past(next_addr[ADDR_W-1:1]));

    // R4: select code 0 reads the MSB flag, the top code reads the LSB flag
    a_r4_first_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == 2'b01 && !halt && test_sel == '0)
        |=> mpc_o[0] == $past(alu_flags[FLAG_N-1]));
    a_r4_last_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == 2'b01 && !halt && test_sel == SEL_W'(FLAG_N-1))
        |=> mpc_o[0] == $past(alu_flags[0]));

    // R5: upper-nibble dispatch
    a_r5_dispatch_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == 2'b10 && !halt)
        |=> mpc_o == {$past(next_addr[ADDR_W-1:NIB_W]), $past(ir[IR_W-1:NIB_W])});

    // R6: lower-nibble dispatch
    a_r6_dispatch_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == 2'b11 && !halt)
        |=> mpc_o == {$past(next_addr[ADDR_W-1:NIB_W]), $past(ir[NIB_W-1:0])});

    // R7: halt holds the counter
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(mpc_o));
endmodule

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       halt;
    logic [8:0] next_addr;
    logic [1:0] cond_mode;
    logic [1:0] test_sel;
    logic [3:0] alu_flags;
    logic [7:0] ir;
    logic [8:0] mpc_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_next_addr dut_i (
        .clk(clk), .rst_n(rst_n), .halt(halt), .next_addr(next_addr),
        .cond_mode(cond_mode), .test_sel(test_sel), .alu_flags(alu_flags),
        .ir(ir), .mpc_o(mpc_o)
    );

    task automatic chk(input string req, input logic [8:0] exp);
        n_checks++;
        if (mpc_o !== exp) begin
            n_fails++;
            $display("FAIL %s: mpc_o=%h expected=%h", req, mpc_o, exp);
        end
    endtask

    // Apply inputs at the falling edge, then sample just after the rising edge.
    task automatic step(input logic rn, input logic h, input logic [8:0] na,
                        input logic [1:0] md, input logic [1:0] ts,
                        input logic [3:0] fl, input logic [7:0] irv);
        @(negedge clk);
        rst_n = rn; halt = h; next_addr = na; cond_mode = md;
        test_sel = ts; alu_flags = fl; ir = irv;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        step(1'b0, 1'b0, 9'h1A5, 2'b00, 2'b00, 4'h0, 8'h00);
        chk("R1 reset state", 9'h000);
        step(1'b1, 1'b0, 9'h0F3, 2'b00, 2'b00, 4'h0, 8'h00);
        chk("R2 load after reset", 9'h0F3);
        step(1'b0, 1'b1, 9'h1FF, 2'b00, 2'b00, 4'h0, 8'h00);
        chk("R8 reset over halt", 9'h000);
        step(1'b0, 1'b1, 9'h1FF, 2'b00, 2'b00, 4'h0, 8'h00);
        chk("R8 reset over halt, second edge", 9'h000);
        step(1'b1, 1'b0, 9'h000, 2'b00, 2'b00, 4'h0, 8'h00);
    endtask

    task automatic t_jump();
        logic [8:0] pats [4] = '{9'h000, 9'h1FF, 9'h155, 9'h0AA};
        foreach (pats[i]) begin
            step(1'b1, 1'b0, pats[i], 2'b00, 2'b11, 4'hF, 8'hFF);
            chk("R2 jump", pats[i]);
        end
    endtask

    task automatic t_flag();
        for (int s = 0; s < 4; s++) begin
            logic [3:0] only = 4'b1000 >> s;
            step(1'b1, 1'b0, 9'h0C6, 2'b01, 2'(s), only, 8'h00);
            chk($sformatf("R3 R4 flag branch sel=%0d set", s), 9'h0C7);
            step(1'b1, 1'b0, 9'h13B, 2'b01, 2'(s), ~only, 8'h00);
            chk($sformatf("R3 R4 flag branch sel=%0d clear", s), 9'h13A);
        end
    endtask

    task automatic t_dispatch();
        logic [7:0] ops [3] = '{8'h3A, 8'hC5, 8'h71};
        foreach (ops[i]) begin
            step(1'b1, 1'b0, 9'h1AF, 2'b10, 2'b00, 4'h0, ops[i]);
            chk("R5 upper nibble dispatch", {5'h1A, ops[i][7:4]});
            step(1'b1, 1'b0, 9'h050, 2'b11, 2'b00, 4'h0, ops[i]);
            chk("R6 lower nibble dispatch", {5'h05, ops[i][3:0]});
        end
    endtask

    task automatic t_halt();
        step(1'b1, 1'b0, 9'h123, 2'b00, 2'b00, 4'h0, 8'h00);
        chk("R7 setup", 9'h123);
        step(1'b1, 1'b1, 9'h0FF, 2'b00, 2'b00, 4'hF, 8'hFF);
        chk("R7 halt jump", 9'h123);
        step(1'b1, 1'b1, 9'h000, 2'b10, 2'b01, 4'hF, 8'hE7);
        chk("R7 halt dispatch", 9'h123);
        step(1'b1, 1'b1, 9'h001, 2'b01, 2'b11, 4'h0, 8'h00);
        chk("R7 halt flag branch", 9'h123);
        step(1'b1, 1'b0, 9'h0EE, 2'b00, 2'b00, 4'h0, 8'h00);
        chk("R7 release", 9'h0EE);
    endtask

    task automatic t_sample();
        step(1'b1, 1'b0, 9'h104, 2'b11, 2'b00, 4'h0, 8'h9B);
        chk("R9 edge value", 9'h10B);
        next_addr = 9'h0FF; cond_mode = 2'b00; ir = 8'h00;
        #2;
        chk("R9 no change between edges", 9'h10B);
        @(posedge clk);
        #1;
        chk("R9 next edge takes new value", 9'h0FF);
    endtask

    initial begin
        rst_n = 1'b0; halt = 1'b0; next_addr = '0; cond_mode = '0;
        test_sel = '0; alu_flags = '0; ir = '0;
        t_reset();
        t_jump();
        t_flag();
        t_dispatch();
        t_halt();
        t_sample();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (R1 to R9 run): actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule